// File: doc/BRIEF.md
# Precise Exception Entry Controller

This block sits at the completion end of a simple in-order pipeline and decides, cycle by cycle, whether control must leave for a handler. It watches the instruction in the completion slot for instruction-caused faults (program, floating-point, trap and system call), a line that says the execution units hold no instruction, a set of maskable interrupt request lines, and two nonmaskable request lines (system reset and machine check). When it takes an event it pulses a flush for one cycle and, in the same cycle, presents the restart address, a copy of the machine state word and a 4-bit cause code.

Instruction faults are precise. A program or floating-point fault saves the address of the faulting instruction. A trap or system call saves the address of the following instruction. Floating-point faults stay precise whatever floating-point mode is in force; the mode in force is recorded in the saved status word. Maskable requests are gated by an enable bit in the controller's state word. They wait for an instruction boundary, or are taken at once when the pipeline is empty. Nonmaskable requests are taken on their rising edge whatever the enable bit says. Whether the interrupted state can be resumed is reported through a recoverability bit in the saved status word. A return pulse restores the state word from the saved copy and re-opens the maskable sources.

Top module: `precise_exc_ctrl`

## Requirements
- R1: After reset, flush, save_pc, save_st and vec are all zero, and the state word holds 0x03 (bit 0 enable = 1, bit 1 recoverable = 1).
- R2: A program fault (code 3) or floating-point fault (code 4) on a valid completing instruction gives flush one cycle later, with save_pc equal to cur_pc of the faulting cycle.
- R3: A trap (code 5) or system call (code 6) on a valid completing instruction saves nxt_pc instead of cur_pc.
- R4: A floating-point fault is taken the same way for every value of fpu_mode (0 to 3). Bits [3:2] of save_st carry the fpu_mode value sampled with the event, for every event.
- R5: An enabled maskable request is taken at the completion of a non-faulting valid instruction, saving nxt_pc. Its code is 8 plus the index of its line (line 0 gives 8, line 4 gives 12).
- R6: With pipe_empty high and no valid completion, an enabled maskable request is taken at once, saving cur_pc.
- R7: A maskable request causes no flush while the enable bit is clear, or while there is neither a valid completion nor an empty pipeline.
- R8: A rising edge on nmi_mchk (code 2) or nmi_reset (code 1) is taken whatever the enable bit, saving cur_pc. A line held high gives only one event.
- R9: Priority, highest first: reset, machine check, program, floating-point, trap, system call, maskable lines (lowest index first). A nonmaskable request that loses is held and taken later. A lost maskable request stays pending while its line is held.
- R10: On every event, save_st receives the state word from before the event and the enable bit is cleared, so held maskable requests are not taken.
- R11: A nonmaskable event taken while a handler is active (an event taken, no rfi since) saves bit 1 of save_st as 0.
- R12: An rfi pulse restores the state word from save_st and ends the active handler, so an enabled pending maskable request is taken one cycle after the restore.
- R13: Completion inputs presented during the flush cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | An instruction completes this cycle |
| flt_prog | input | 1 | Completing instruction raised a program fault |
| flt_fpu | input | 1 | Completing instruction raised a floating-point fault |
| flt_trap | input | 1 | Completing instruction is a taken trap |
| flt_scall | input | 1 | Completing instruction is a system call |
| fpu_mode | input | 2 | Floating-point exception mode in force |
| pipe_empty | input | 1 | No instruction in the execution units |
| cur_pc | input | AW | Address of the completing, or next to run, instruction |
| nxt_pc | input | AW | Address of the instruction after it |
| irq_mask | input | NMASK | Maskable request lines, index 0 highest priority |
| nmi_reset | input | 1 | System reset request |
| nmi_mchk | input | 1 | Machine check request |
| rfi | input | 1 | Return-from-handler pulse |
| flush | output | 1 | One-cycle pipeline flush on event entry |
| save_pc | output | AW | Saved restart address |
| save_st | output | SW | Saved state word |
| vec | output | 4 | Cause code of the last event |

## Verification
The assertions assume that a maskable request line stays high until its handler is entered, and that rfi is only pulsed while a handler is active. The bench drives each maskable line from before the decision edge until the flush becomes visible, and then drops it. It pulses rfi only after a flush has been seen. The assertions also take cur_pc and nxt_pc as the addresses that belong to the completion slot in the same cycle as its fault flags. The bench changes the addresses only between scenarios and never next to a decision edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_NONE      = 4'd0;
  localparam logic [VEC_W-1:0] VEC_RESET     = 4'd1;
  localparam logic [VEC_W-1:0] VEC_MCHK      = 4'd2;
  localparam logic [VEC_W-1:0] VEC_PROG      = 4'd3;
  localparam logic [VEC_W-1:0] VEC_FPU       = 4'd4;
  localparam logic [VEC_W-1:0] VEC_TRAP      = 4'd5;
  localparam logic [VEC_W-1:0] VEC_SCALL     = 4'd6;
  localparam logic [VEC_W-1:0] VEC_MASK_BASE = 4'd8;

  // index of each nonmaskable source in the pending vector
  localparam int NM_RESET = 0;
  localparam int NM_MCHK  = 1;
  localparam int NM_COUNT = 2;

  typedef struct packed {
    logic prog;
    logic fpu;
    logic trap;
    logic scall;
  } fault_t;
endpackage

// File: rtl/exc_nm_latch.sv
// Rising-edge capture of nonmaskable requests, held until the selector takes them.
module exc_nm_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic req_d;
    logic hold_q;
    logic rise;

    assign rise    = req[i] & ~req_d;
    assign pend[i] = hold_q | rise;

    always_ff @(posedge clk) begin
      if (rst) begin
        req_d  <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        req_d  <= req[i];
        hold_q <= pend[i] & ~clr[i];
      end
    end
  end
endmodule

// File: rtl/exc_select.sv
// Combinational priority choice of the event to take and its restart address.
module exc_select
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NMASK = 5
) (
  input  logic [NM_COUNT-1:0] pend_nm,
  input  logic                cmp_valid,
  input  fault_t              flt,
  input  logic                blocked,
  input  logic                ee,
  input  logic                pipe_empty,
  input  logic [NMASK-1:0]    irq,
  input  logic [AW-1:0]       cur_pc,
  input  logic [AW-1:0]       nxt_pc,
  output logic                take,
  output logic                nm_take,
  output logic [NM_COUNT-1:0] nm_clr,
  output logic [VEC_W-1:0]    vec,
  output logic [AW-1:0]       epc
);
  logic slot;
  logic mask_hit;
  int   mask_idx;

  assign slot = cmp_valid & ~blocked;

  // lowest index wins among maskable lines
  always_comb begin
    mask_hit = 1'b0;
    mask_idx = 0;
    for (int i = NMASK - 1; i >= 0; i--) begin
      if (irq[i]) begin
        mask_hit = 1'b1;
        mask_idx = i;
      end
    end
  end

  always_comb begin
    take    = 1'b0;
    nm_take = 1'b0;
    nm_clr  = '0;
    vec     = VEC_NONE;
    epc     = cur_pc;
    if (pend_nm[NM_RESET]) begin
      take             = 1'b1;
      nm_take          = 1'b1;
      nm_clr[NM_RESET] = 1'b1;
      vec              = VEC_RESET;
    end else if (pend_nm[NM_MCHK]) begin
      take            = 1'b1;
      nm_take         = 1'b1;
      nm_clr[NM_MCHK] = 1'b1;
      vec             = VEC_MCHK;
    end else if (slot && flt.prog) begin
      take = 1'b1;
      vec  = VEC_PROG;
    end else if (slot && flt.fpu) begin
      take = 1'b1;
      vec  = VEC_FPU;
    end else if (slot && flt.trap) begin
      take = 1'b1;
      vec  = VEC_TRAP;
      epc  = nxt_pc;
    end else if (slot && flt.scall) begin
      take = 1'b1;
      vec  = VEC_SCALL;
      epc  = nxt_pc;
    end else if (ee && mask_hit && (slot || pipe_empty)) begin
      take = 1'b1;
      vec  = VEC_MASK_BASE + VEC_W'(mask_idx);
      epc  = slot ? nxt_pc : cur_pc;
    end
  end
endmodule

// File: rtl/exc_state.sv
// Machine state word and handler-active flag; builds the status word to save.
module exc_state #(
  parameter int              SW       = 8,
  parameter int              EE_BIT   = 0,
  parameter int              RI_BIT   = 1,
  parameter int              FP_LSB   = 2,
  parameter logic [SW-1:0]   MSR_INIT = 'h3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          nm_take,
  input  logic          rfi,
  input  logic [SW-1:0] restore,
  input  logic [1:0]    fpu_mode,
  output logic [SW-1:0] msr,
  output logic          in_hnd,
  output logic [SW-1:0] save_st
);
  logic [SW-1:0] msr_q;
  logic          in_hnd_q;

  always_comb begin
    save_st                = msr_q;
    save_st[FP_LSB +: 2]   = fpu_mode;
    if (nm_take && in_hnd_q) begin
      save_st[RI_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q    <= MSR_INIT;
      in_hnd_q <= 1'b0;
    end else if (take) begin
      msr_q[EE_BIT] <= 1'b0;
      in_hnd_q      <= 1'b1;
    end else if (rfi) begin
      msr_q    <= restore;
      in_hnd_q <= 1'b0;
    end
  end

  assign msr    = msr_q;
  assign in_hnd = in_hnd_q;
endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
  import exc_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            SW       = 8,
  parameter int            NMASK    = 5,
  parameter int            EE_BIT   = 0,
  parameter int            RI_BIT   = 1,
  parameter int            FP_LSB   = 2,
  parameter logic [SW-1:0] MSR_INIT = 'h3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_valid,
  input  logic             flt_prog,
  input  logic             flt_fpu,
  input  logic             flt_trap,
  input  logic             flt_scall,
  input  logic [1:0]       fpu_mode,
  input  logic             pipe_empty,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    nxt_pc,
  input  logic [NMASK-1:0] irq_mask,
  input  logic             nmi_reset,
  input  logic             nmi_mchk,
  input  logic             rfi,
  output logic             flush,
  output logic [AW-1:0]    save_pc,
  output logic [SW-1:0]    save_st,
  output logic [3:0]       vec
);
  localparam int CODE_ROOM = (1 << VEC_W) - int'(VEC_MASK_BASE);

  initial begin
    if (NMASK > CODE_ROOM) $error("NMASK exceeds the cause code range");
  end

  fault_t                flt;
  logic [NM_COUNT-1:0]   nm_req;
  logic [NM_COUNT-1:0]   nm_pend;
  logic [NM_COUNT-1:0]   nm_clr;
  logic                  take;
  logic                  nm_take;
  logic [VEC_W-1:0]      sel_vec;
  logic [AW-1:0]         sel_pc;
  logic [SW-1:0]         msr_q;
  logic                  in_hnd_q;
  logic [SW-1:0]         st_next;

  logic                  flush_q;
  logic [AW-1:0]         save_pc_q;
  logic [SW-1:0]         save_st_q;
  logic [VEC_W-1:0]      vec_q;

  assign flt              = '{prog: flt_prog, fpu: flt_fpu, trap: flt_trap, scall: flt_scall};
  assign nm_req[NM_RESET] = nmi_reset;
  assign nm_req[NM_MCHK]  = nmi_mchk;

  exc_nm_latch #(.N(NM_COUNT)) u_nm (
    .clk  (clk),
    .rst  (rst),
    .req  (nm_req),
    .clr  (nm_clr),
    .pend (nm_pend)
  );

  exc_select #(.AW(AW), .NMASK(NMASK)) u_sel (
    .pend_nm    (nm_pend),
    .cmp_valid  (cmp_valid),
    .flt        (flt),
    .blocked    (flush_q),
    .ee         (msr_q[EE_BIT]),
    .pipe_empty (pipe_empty),
    .irq        (irq_mask),
    .cur_pc     (cur_pc),
    .nxt_pc     (nxt_pc),
    .take       (take),
    .nm_take    (nm_take),
    .nm_clr     (nm_clr),
    .vec        (sel_vec),
    .epc        (sel_pc)
  );

  exc_state #(
    .SW(SW), .EE_BIT(EE_BIT), .RI_BIT(RI_BIT), .FP_LSB(FP_LSB), .MSR_INIT(MSR_INIT)
  ) u_st (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .nm_take  (nm_take),
    .rfi      (rfi),
    .restore  (save_st_q),
    .fpu_mode (fpu_mode),
    .msr      (msr_q),
    .in_hnd   (in_hnd_q),
    .save_st  (st_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q   <= 1'b0;
      save_pc_q <= '0;
      save_st_q <= '0;
      vec_q     <= VEC_NONE;
    end else begin
      flush_q <= take;
      if (take) begin
        save_pc_q <= sel_pc;
        save_st_q <= st_next;
        vec_q     <= sel_vec;
      end
    end
  end

  assign flush   = flush_q;
  assign save_pc = save_pc_q;
  assign save_st = save_st_q;
  assign vec     = vec_q;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int AW     = 32,
  parameter int SW     = 8,
  parameter int RI_BIT = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic [3:0]    vec,
  input logic [AW-1:0] save_pc,
  input logic [SW-1:0] save_st,
  input logic [AW-1:0] cur_pc,
  input logic [AW-1:0] nxt_pc,
  input logic          ee,
  input logic          in_hnd
);
  AST_PRECISE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (flush && (vec == 4'd3 || vec == 4'd4)) |-> (save_pc == $past(cur_pc))); // R2

  AST_TRAP_NEXT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (flush && (vec == 4'd5 || vec == 4'd6)) |-> (save_pc == $past(nxt_pc))); // R3

  AST_MASKABLE_GATED: assert property (@(posedge clk) disable iff (rst)
    (flush && vec >= 4'd8) |-> $past(ee)); // R7

  AST_ENTRY_CLEARS_EE: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!ee && in_hnd && vec != 4'd0)); // R10

  AST_NESTED_UNRECOVERABLE: assert property (@(posedge clk) disable iff (rst)
    (flush && (vec == 4'd1 || vec == 4'd2) && $past(in_hnd)) |-> !save_st[RI_BIT]); // R11

  AST_NM_ADDR: assert property (@(posedge clk) disable iff (rst)
    (flush && (vec == 4'd1 || vec == 4'd2)) |-> (save_pc == $past(cur_pc))); // R8
endmodule

bind precise_exc_ctrl exc_ctrl_chk #(.AW(AW), .SW(SW), .RI_BIT(RI_BIT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .flush   (flush),
  .vec     (vec),
  .save_pc (save_pc),
  .save_st (save_st),
  .cur_pc  (cur_pc),
  .nxt_pc  (nxt_pc),
  .ee      (msr_q[EE_BIT]),
  .in_hnd  (in_hnd_q)
);

// File: tb/precise_exc_ctrl_test.sv
module precise_exc_ctrl_test;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam int NMASK = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_valid = 0, flt_prog = 0, flt_fpu = 0, flt_trap = 0, flt_scall = 0;
  logic [1:0] fpu_mode = 2'd0;
  logic pipe_empty = 0;
  logic [AW-1:0] cur_pc = 32'h100, nxt_pc = 32'h104;
  logic [NMASK-1:0] irq_mask = '0;
  logic nmi_reset = 0, nmi_mchk = 0, rfi = 0;
  logic flush;
  logic [AW-1:0] save_pc;
  logic [SW-1:0] save_st;
  logic [3:0] vec;

  always #5 clk = ~clk;

  precise_exc_ctrl uut (
    .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .flt_prog(flt_prog), .flt_fpu(flt_fpu),
    .flt_trap(flt_trap), .flt_scall(flt_scall), .fpu_mode(fpu_mode), .pipe_empty(pipe_empty),
    .cur_pc(cur_pc), .nxt_pc(nxt_pc), .irq_mask(irq_mask), .nmi_reset(nmi_reset),
    .nmi_mchk(nmi_mchk), .rfi(rfi), .flush(flush), .save_pc(save_pc), .save_st(save_st), .vec(vec)
  );

  int checks = 0;
  int fails = 0;
  logic [3:0]    q_vec[$];
  logic [AW-1:0] q_pc[$];
  logic [SW-1:0] q_st[$];
  string         q_tag[$];

  logic [SW-1:0] msr_m = 8'h03;
  logic [SW-1:0] last_st = 8'h00;
  bit            inh_m = 0;

  // monitor: every flush must match the oldest expected entry
  always @(negedge clk) begin
    if (!rst && flush) begin
      checks++;
      if (q_vec.size() == 0) begin
        fails++;
        $display("FAIL R7 R13: unexpected flush vec=%0d pc=%h, expected no event", vec, save_pc);
      end else begin
        logic [3:0] ev;
        logic [AW-1:0] ep;
        logic [SW-1:0] es;
        string et;
        ev = q_vec.pop_front();
        ep = q_pc.pop_front();
        es = q_st.pop_front();
        et = q_tag.pop_front();
        if (vec !== ev || save_pc !== ep || save_st !== es) begin
          fails++;
          $display("FAIL %s: vec=%0d pc=%h st=%h, expected vec=%0d pc=%h st=%h",
                   et, vec, save_pc, save_st, ev, ep, es);
        end
      end
    end
  end

  task automatic push_exp(input logic [3:0] v, input logic [AW-1:0] pc, input bit nm, input string tag);
    logic [SW-1:0] s;
    s = msr_m;
    s[3:2] = fpu_mode;
    if (nm && inh_m) s[1] = 1'b0;
    q_vec.push_back(v);
    q_pc.push_back(pc);
    q_st.push_back(s);
    q_tag.push_back(tag);
    last_st = s;
    msr_m[0] = 1'b0;
    inh_m = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    checks++;
    if (q_vec.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d event(s) not taken, expected 0 outstanding", tag, q_vec.size());
      q_vec.delete(); q_pc.delete(); q_st.delete(); q_tag.delete();
    end
  endtask

  task automatic do_rfi();
    @(negedge clk);
    rfi = 1'b1;
    msr_m = last_st;
    inh_m = 1'b0;
    @(negedge clk);
    rfi = 1'b0;
  endtask

  // kind: 0 program, 1 floating-point, 2 trap, 3 system call
  task automatic sync_fault(input int kind, input string tag);
    @(negedge clk);
    cmp_valid = 1'b1;
    case (kind)
      0: begin flt_prog = 1'b1;  push_exp(4'd3, cur_pc, 0, tag); end
      1: begin flt_fpu = 1'b1;   push_exp(4'd4, cur_pc, 0, tag); end
      2: begin flt_trap = 1'b1;  push_exp(4'd5, nxt_pc, 0, tag); end
      default: begin flt_scall = 1'b1; push_exp(4'd6, nxt_pc, 0, tag); end
    endcase
    @(negedge clk);
    cmp_valid = 0; flt_prog = 0; flt_fpu = 0; flt_trap = 0; flt_scall = 0;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    msr_m = 8'h03;
    inh_m = 1'b0;
    last_st = 8'h00;
  endtask

  task automatic check_reset_state();
    checks++;
    if (flush !== 1'b0 || save_pc !== '0 || save_st !== '0 || vec !== 4'd0) begin
      fails++;
      $display("FAIL R1: flush=%b pc=%h st=%h vec=%0d, expected all zero", flush, save_pc, save_st, vec);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    check_reset_state();                                   // R1

    // R2: program fault saves faulting address
    sync_fault(0, "R2 program");
    do_rfi(); drained("R2");

    // R13: completion presented during flush cycle is ignored
    @(negedge clk);
    cmp_valid = 1; flt_prog = 1; push_exp(4'd3, cur_pc, 0, "R13 first");
    @(negedge clk);
    flt_prog = 0; flt_trap = 1;                            // during flush
    @(negedge clk);
    cmp_valid = 0; flt_trap = 0;
    idle(2); drained("R13");
    do_rfi();

    // R4: floating-point fault precise in every mode
    for (int m = 0; m < 4; m++) begin
      fpu_mode = 2'(m);
      sync_fault(1, "R4 fp mode");
      do_rfi(); drained("R4");
    end
    fpu_mode = 2'd0;

    // R3: trap and system call save next address
    cur_pc = 32'h0000_2000; nxt_pc = 32'h0000_2004;
    sync_fault(2, "R3 trap");
    do_rfi();
    sync_fault(3, "R3 scall");
    do_rfi(); drained("R3");

    // R7 then R5: maskable waits for a boundary, then taken with next address
    @(negedge clk);
    irq_mask = 5'b00001;
    idle(3);
    drained("R7 no boundary");
    cmp_valid = 1'b1;
    push_exp(4'd8, nxt_pc, 0, "R5 external at completion");
    @(negedge clk);
    cmp_valid = 1'b0;
    @(negedge clk);
    irq_mask = '0;
    do_rfi(); drained("R5");

    // R6: empty pipeline takes maskable at once with current address
    @(negedge clk);
    irq_mask = 5'b00010; pipe_empty = 1'b1;
    push_exp(4'd9, cur_pc, 0, "R6 empty pipeline");
    @(negedge clk);
    irq_mask = '0; pipe_empty = 1'b0;
    do_rfi(); drained("R6");

    // R9: lower maskable index wins
    @(negedge clk);
    irq_mask = 5'b11000; pipe_empty = 1'b1;
    push_exp(4'd11, cur_pc, 0, "R9 maskable order");
    @(negedge clk);
    irq_mask = '0; pipe_empty = 1'b0;
    do_rfi(); drained("R9 order");

    // R10 and R12: held request blocked inside handler, taken after return
    @(negedge clk);
    irq_mask = 5'b10000; pipe_empty = 1'b1;
    push_exp(4'd12, cur_pc, 0, "R10 thermal entry");
    idle(5);
    drained("R10 blocked while enable clear");
    rfi = 1'b1;
    msr_m = last_st; inh_m = 1'b0;
    push_exp(4'd12, cur_pc, 0, "R12 taken after return");
    @(negedge clk);
    rfi = 1'b0;
    @(negedge clk);
    irq_mask = '0; pipe_empty = 1'b0;
    idle(1); drained("R12");
    do_rfi();

    // R8: machine check, held line gives one event; R11 nested reset
    cur_pc = 32'h0000_0200; nxt_pc = 32'h0000_0204;
    @(negedge clk);
    nmi_mchk = 1'b1;
    push_exp(4'd2, cur_pc, 1, "R8 machine check");
    idle(3);
    nmi_mchk = 1'b0;
    drained("R8 single event");
    nmi_reset = 1'b1;
    push_exp(4'd1, cur_pc, 1, "R11 nested reset");
    @(negedge clk);
    nmi_reset = 1'b0;
    idle(2); drained("R11");

    apply_reset();
    idle(1);
    check_reset_state();                                   // R1 again

    // R9: all sources at once
    cur_pc = 32'h0000_0300; nxt_pc = 32'h0000_0304;
    @(negedge clk);
    nmi_reset = 1; nmi_mchk = 1; cmp_valid = 1; flt_prog = 1; irq_mask = 5'b00001;
    push_exp(4'd1, cur_pc, 1, "R9 reset first");
    push_exp(4'd2, cur_pc, 1, "R9 mchk held then taken");
    @(negedge clk);
    nmi_reset = 0; nmi_mchk = 0; cmp_valid = 0; flt_prog = 0;
    idle(2);
    irq_mask = '0;
    idle(1); drained("R9 all sources");

    apply_reset();
    // R9: synchronous fault beats maskable
    @(negedge clk);
    cmp_valid = 1; flt_prog = 1; irq_mask = 5'b00001;
    push_exp(4'd3, cur_pc, 0, "R9 fault over maskable");
    @(negedge clk);
    cmp_valid = 0; flt_prog = 0;
    @(negedge clk);
    irq_mask = '0;
    idle(2); drained("R9 fault over maskable");

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule